// File: doc/BRIEF.md
# Stepper Motor Pulse Generator

This block produces the drive pattern for a two-terminal bipolar stepping motor in a quartz watch. It runs on a 32768 Hz clock and receives a one-cycle 1 Hz tick. An 8-bit configuration word selects the step period, the width of the primary pulse, full or chopped drive, and an optional low-duty tail after each pulse. Every step flips the current direction through the motor coil. Between steps both terminals sit at the supply level, so the winding is shorted.

A debounced stop input halts stepping and opens the motor switches. After release, stepping resumes one full period later with the opposite polarity to the last pulse. A test input replaces the programmed period with a 32 Hz step rate, derived internally by dividing the clock by 1024, so the mechanics can be exercised quickly.

The behaviour is a four-state machine:
- `PH_IDLE`: coil shorted; a step request moves it to `PH_MAIN`.
- `PH_MAIN`: the primary pulse. At its last cycle it goes to `PH_TAIL` when the tail is enabled, otherwise back to `PH_IDLE`.
- `PH_TAIL`: the stretch segment, which returns to `PH_IDLE` at its last cycle.
- `PH_HALT`: switches open. Any state enters it while the debounced stop is high, and it returns to `PH_IDLE` when the stop is released.

Top module: `motor_step_gen`

## Requirements
- R1: After reset `sw_en`=1 and `drv_a`=`drv_b`=1, which is the shorted idle state.
- R2: `cfg[2:0]`=n sets the primary pulse length to (n+1)*32 clock cycles. The pulse starts in the cycle after the edge that accepts the step.
- R3: `cfg[5:3]` selects the period in 1 Hz ticks: 000=1, 001=5, 010=10, 011=20, 100=30. A pulse starts only on the period-th tick counted from reset, from the previous pulse, or from the end of a stop or test interval.
- R4: Period codes 101, 110 and 111 behave as a 1-tick period.
- R5: `cfg[6]`=1 drives for every cycle of the primary pulse. `cfg[6]`=0 chops the pulse on a 4-cycle frame: 3 cycles driven, then 1 cycle shorted.
- R6: `cfg[7]`=1 appends a tail right after the primary pulse. The tail is twice the primary length and is driven only in the first cycle of each 4-cycle frame.
- R7: Pulse polarity alternates on every pulse. Polarity 0 (`drv_a`=1, `drv_b`=0) comes first after reset, and polarity 1 is `drv_a`=0, `drv_b`=1. A cycle that is not driven shows `drv_a`=`drv_b`=1.
- R8: While the debounced stop is active, `sw_en`=`drv_a`=`drv_b`=0 and 1 Hz ticks produce no pulse.
- R9: `stop_req` is sampled on the internal 32 Hz strobe and takes effect only after two equal consecutive samples. A high level shorter than 1024 cycles is ignored. A held level is acted on after 1025 to 2049 cycles.
- R10: After stop release, the first pulse comes on the period-th tick and has the opposite polarity to the last pulse before the stop.
- R11: While `test_req`=1, pulses start every 1024 cycles regardless of the 1 Hz tick, and they still alternate in polarity.
- R12: `drv_a` and `drv_b` are never both low while `sw_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| cfg | input | 8 | Configuration word: width, period, duty, tail |
| stop_req | input | 1 | Stop request (debounced inside) |
| test_req | input | 1 | Fast 32 Hz stepping request |
| drv_a | output | 1 | Drive level of terminal A |
| drv_b | output | 1 | Drive level of terminal B |
| sw_en | output | 1 | Motor switch enable (0 = open) |

## Verification
Each tick is followed by a cycle-exact comparison of the whole pulse window against a waveform computed from the configuration. This separates an off-by-one in pulse length, a shifted chop frame, or a tail of the wrong length or duty.

Directed words cover the extreme widths, every period code including the unused ones, and the stop and test sequences. Random words drawn from a fixed seed mix widths, duty and tail settings, so combinations the directed cases miss are also compared.

The stop is first tried with a short glitch and then with a held level. The glitch shows the two-sample filter, and the held level measures the latency window, the silence during the halt and the polarity after restart. Test mode is checked by the spacing between pulse starts and by polarity continuity when it is left.

// File: rtl/msg_pkg.sv
package msg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MAIN = 2'd1,
        PH_TAIL = 2'd2,
        PH_HALT = 2'd3
    } phase_t;

    // Step period in 1 Hz ticks for a 3-bit period code; unused codes give 1.
    function automatic logic [4:0] period_secs(input logic [2:0] code);
        logic [4:0] r;
        case (code)
            3'd1:    r = 5'd5;
            3'd2:    r = 5'd10;
            3'd3:    r = 5'd20;
            3'd4:    r = 5'd30;
            default: r = 5'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/msg_rate.sv
module msg_rate
    import msg_pkg::*;
#(
    parameter int DIV   = 1024,
    parameter int SEC_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic [2:0] per_code,
    input  logic       test_mode,
    input  logic       halt,
    output logic       tick32,
    output logic       step_go
);
    localparam int PRE_W = $clog2(DIV);

    logic [PRE_W-1:0] pre_q;
    logic [SEC_W-1:0] sec_q;
    logic [SEC_W-1:0] lim;
    logic             last_sec;

    assign tick32   = (pre_q == PRE_W'(DIV - 1));
    assign lim      = SEC_W'(period_secs(per_code));
    assign last_sec = (sec_q >= lim - SEC_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= tick32 ? '0 : pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 sec_q <= '0;
        else if (halt || test_mode) sec_q <= '0;
        else if (tick_1hz)          sec_q <= last_sec ? '0 : sec_q + SEC_W'(1);
    end

    always_comb begin
        if (halt)           step_go = 1'b0;
        else if (test_mode) step_go = tick32;
        else                step_go = tick_1hz && last_sec;
    end
endmodule

// File: rtl/msg_debounce.sv
module msg_debounce (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic raw,
    output logic level
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            level  <= 1'b0;
        end else if (sample_en) begin
            prev_q <= raw;
            if (raw == prev_q) level <= raw;
        end
    end
endmodule

// File: rtl/msg_pulse_fsm.sv
module msg_pulse_fsm
    import msg_pkg::*;
#(
    parameter int UNIT     = 32,
    parameter int SEG_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_go,
    input  logic                halt,
    input  logic [2:0]          wcode,
    input  logic                full_duty,
    input  logic                stretch,
    output logic                drv_a,
    output logic                drv_b,
    output logic                sw_en,
    output phase_t              phase,
    output logic [SEG_BITS-1:0] seg_cnt,
    output logic                cur_pol,
    output logic                start
);
    phase_t              phase_q, phase_d;
    logic [SEG_BITS-1:0] seg_q, seg_d;
    logic                cur_q, cur_d, nxt_q, nxt_d;
    logic [SEG_BITS-1:0] main_len, main_last, tail_last;
    logic                on;

    assign main_len  = (SEG_BITS'(wcode) + SEG_BITS'(1)) * SEG_BITS'(UNIT);
    assign main_last = main_len - SEG_BITS'(1);
    assign tail_last = (main_len << 1) - SEG_BITS'(1);
    assign start     = (phase_q == PH_IDLE) && !halt && step_go;

    always_comb begin
        phase_d = phase_q;
        seg_d   = seg_q;
        cur_d   = cur_q;
        nxt_d   = nxt_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (halt) phase_d = PH_HALT;
                else if (step_go) begin
                    phase_d = PH_MAIN;
                    seg_d   = '0;
                    cur_d   = nxt_q;
                    nxt_d   = !nxt_q;
                end
            end
            PH_MAIN: begin
                if (halt) phase_d = PH_HALT;
                else if (seg_q == main_last) begin
                    phase_d = stretch ? PH_TAIL : PH_IDLE;
                    seg_d   = '0;
                end else seg_d = seg_q + SEG_BITS'(1);
            end
            PH_TAIL: begin
                if (halt) phase_d = PH_HALT;
                else if (seg_q == tail_last) begin
                    phase_d = PH_IDLE;
                    seg_d   = '0;
                end else seg_d = seg_q + SEG_BITS'(1);
            end
            PH_HALT: begin
                if (!halt) phase_d = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            seg_q   <= '0;
            cur_q   <= 1'b1;
            nxt_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            seg_q   <= seg_d;
            cur_q   <= cur_d;
            nxt_q   <= nxt_d;
        end
    end

    always_comb begin
        on    = 1'b0;
        sw_en = 1'b1;
        drv_a = 1'b1;
        drv_b = 1'b1;
        unique case (phase_q)
            PH_IDLE: on = 1'b0;
            PH_MAIN: on = full_duty || (seg_q[1:0] != 2'd3);
            PH_TAIL: on = (seg_q[1:0] == 2'd0);
            PH_HALT: begin
                sw_en = 1'b0;
                drv_a = 1'b0;
                drv_b = 1'b0;
            end
        endcase
        if (on) begin
            drv_a = !cur_q;
            drv_b = cur_q;
        end
    end

    assign phase   = phase_q;
    assign seg_cnt = seg_q;
    assign cur_pol = cur_q;
endmodule

// File: rtl/motor_step_gen.sv
module motor_step_gen
    import msg_pkg::*;
#(
    parameter int DIV_32HZ = 1024,
    parameter int UNIT_CYC = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic [7:0] cfg,
    input  logic       stop_req,
    input  logic       test_req,
    output logic       drv_a,
    output logic       drv_b,
    output logic       sw_en
);
    localparam int SEG_BITS = $clog2(2 * 8 * UNIT_CYC) + 1;

    logic                tick32, step_go, stop_db, start, cur_pol;
    phase_t              phase;
    logic [SEG_BITS-1:0] seg_cnt;

    msg_rate #(.DIV(DIV_32HZ), .SEC_W(5)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_1hz (tick_1hz),
        .per_code (cfg[5:3]),
        .test_mode(test_req),
        .halt     (stop_db),
        .tick32   (tick32),
        .step_go  (step_go)
    );

    msg_debounce u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(tick32),
        .raw      (stop_req),
        .level    (stop_db)
    );

    msg_pulse_fsm #(.UNIT(UNIT_CYC), .SEG_BITS(SEG_BITS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_go  (step_go),
        .halt     (stop_db),
        .wcode    (cfg[2:0]),
        .full_duty(cfg[6]),
        .stretch  (cfg[7]),
        .drv_a    (drv_a),
        .drv_b    (drv_b),
        .sw_en    (sw_en),
        .phase    (phase),
        .seg_cnt  (seg_cnt),
        .cur_pol  (cur_pol),
        .start    (start)
    );
endmodule

// File: rtl/msg_checker.sv
module msg_checker
    import msg_pkg::*;
#(
    parameter int SEG_BITS = 10,
    parameter int UNIT     = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                drv_a,
    input logic                drv_b,
    input logic                sw_en,
    input logic                stop_db,
    input logic                start,
    input phase_t              phase,
    input logic [SEG_BITS-1:0] seg_cnt,
    input logic                cur_pol,
    input logic [7:0]          cfg
);
    logic [SEG_BITS-1:0] lim_main;
    assign lim_main = (SEG_BITS'(cfg[2:0]) + SEG_BITS'(1)) * SEG_BITS'(UNIT);

    assert_main_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MAIN) |-> (seg_cnt < lim_main));

    assert_chop_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MAIN && !cfg[6] && seg_cnt[1:0] == 2'd3) |-> (drv_a && drv_b));

    assert_tail_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TAIL && (drv_a ^ drv_b)) |-> (seg_cnt[1:0] == 2'd0));

    assert_pol_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cur_pol != $past(cur_pol)));

    assert_halt_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_db |=> (!sw_en && !drv_a && !drv_b));

    assert_no_both_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |-> (drv_a || drv_b));
endmodule

bind motor_step_gen msg_checker #(.SEG_BITS(SEG_BITS), .UNIT(UNIT_CYC)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .drv_a  (drv_a),
    .drv_b  (drv_b),
    .sw_en  (sw_en),
    .stop_db(stop_db),
    .start  (start),
    .phase  (phase),
    .seg_cnt(seg_cnt),
    .cur_pol(cur_pol),
    .cfg    (cfg)
);

// File: tb/motor_step_gen_tb_top.sv
module motor_step_gen_tb_top;
    localparam int SPAN = 790;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [7:0] cfg = 8'h40;
    logic       stop_req = 1'b0;
    logic       test_req = 1'b0;
    logic       drv_a, drv_b, sw_en;

    int  errors = 0;
    int  checks = 0;
    bit  exp_pol = 1'b0;
    bit  done = 1'b0;

    always #10 clk = !clk;

    motor_step_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .cfg(cfg),
        .stop_req(stop_req), .test_req(test_req),
        .drv_a(drv_a), .drv_b(drv_b), .sw_en(sw_en)
    );

    function automatic int exp_secs(input logic [2:0] code);
        case (code)
            3'd1: return 5;
            3'd2: return 10;
            3'd3: return 20;
            3'd4: return 30;
            default: return 1;
        endcase
    endfunction

    // {sw_en, drv_a, drv_b} at cycle k after a tick
    function automatic logic [2:0] exp_out(input int k, input bit pulse,
                                           input logic [7:0] c, input bit pol,
                                           input bit halted);
        int lm, lt;
        bit on;
        if (halted) return 3'b000;
        lm = (int'(c[2:0]) + 1) * 32;
        lt = c[7] ? 2 * lm : 0;
        on = 1'b0;
        if (pulse && k < lm)           on = c[6] ? 1'b1 : ((k % 4) != 3);
        else if (pulse && k < lm + lt) on = (((k - lm) % 4) == 0);
        if (!on) return 3'b111;
        return pol ? 3'b101 : 3'b110;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_and_check(input bit pulse, input bit halted, input string req);
        int bad = 0;
        int first_k = -1;
        logic [2:0] fa = 3'b0, fe = 3'b0;
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk) tick_1hz = 1'b0;
        for (int k = 0; k < SPAN; k++) begin
            logic [2:0] e;
            e = exp_out(k, pulse, cfg, exp_pol, halted);
            if ({sw_en, drv_a, drv_b} !== e) begin
                if (bad == 0) begin first_k = k; fa = {sw_en, drv_a, drv_b}; fe = e; end
                bad++;
            end
            if (k < SPAN - 1) @(negedge clk);
        end
        if (bad != 0) $display("  first mismatch at cycle %0d", first_k);
        check(bad == 0, req, int'(fa), int'(fe));
        if (pulse) exp_pol = !exp_pol;
    endtask

    task automatic run_period(input string req);
        int lim = exp_secs(cfg[5:3]);
        for (int i = 1; i <= lim; i++) tick_and_check(i == lim, 1'b0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [2:0] codes [5];
        int lat;
        int starts [4];
        bit spols [4];
        int ns;
        bit prev_x;
        int cyc;

        codes[0] = 3'd0; codes[1] = 3'd1; codes[2] = 3'd5; codes[3] = 3'd6; codes[4] = 3'd7;
        seed = $urandom(32'd4711);

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({sw_en, drv_a, drv_b} == 3'b111, "R1", int'({sw_en, drv_a, drv_b}), 7);

        // R2 R7: narrowest full pulse, first polarity 0
        cfg = 8'b0100_0000;
        run_period("R2/R7 width0 full");
        // R2 widest, R5 chop, R6 tail
        cfg = 8'b0000_0111;
        run_period("R5 width7 chopped");
        cfg = 8'b1000_0111;
        run_period("R6 width7 chopped+tail");
        cfg = 8'b1100_0010;
        run_period("R6 width2 full+tail");
        // R3 period codes
        cfg = 8'b0100_1001;
        run_period("R3 period 5");
        cfg = 8'b0101_0000;
        run_period("R3 period 10");
        cfg = 8'b1110_0011;
        run_period("R3 period 30");
        // R4 unused codes
        cfg = 8'b0110_1000;
        run_period("R4 code 5");
        cfg = 8'b0111_0001;
        run_period("R4 code 6");
        cfg = 8'b0011_1100;
        run_period("R4 code 7");

        // random mix
        for (int it = 0; it < 12; it++) begin
            cfg[2:0] = 3'($urandom % 8);
            cfg[5:3] = codes[$urandom % 5];
            cfg[6]   = 1'($urandom % 2);
            cfg[7]   = 1'($urandom % 2);
            run_period("R2/R5/R6 random");
        end

        // R9 glitch is ignored
        cfg = 8'b0100_1000;
        stop_req = 1'b1;
        lat = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (k == 600) stop_req = 1'b0;
            if (!sw_en) lat++;
        end
        check(lat == 0, "R9 glitch", lat, 0);

        // R9 held stop latency
        stop_req = 1'b1;
        lat = 0;
        while (sw_en && lat < 3000) begin @(negedge clk); lat++; end
        check(lat >= 1025 && lat <= 2050, "R9 stop latency", lat, 1025);

        // R8 ticks during halt do nothing
        for (int i = 0; i < 3; i++) tick_and_check(1'b0, 1'b1, "R8 halted");

        // R9 release latency, R10 restart
        stop_req = 1'b0;
        lat = 0;
        while (!sw_en && lat < 3000) begin @(negedge clk); lat++; end
        check(lat >= 1025 && lat <= 2050, "R9 release latency", lat, 1025);
        cfg = 8'b0100_1001;
        run_period("R10 restart period 5");

        // R11 test mode
        cfg = 8'b0100_0000;
        test_req = 1'b1;
        ns = 0;
        prev_x = 1'b0;
        cyc = 0;
        while (ns < 4 && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            if ((drv_a ^ drv_b) && !prev_x) begin
                starts[ns] = cyc;
                spols[ns]  = drv_b;
                ns++;
            end
            prev_x = drv_a ^ drv_b;
        end
        repeat (100) @(negedge clk);
        test_req = 1'b0;
        check(ns == 4, "R11 pulse count", ns, 4);
        for (int i = 0; i < ns; i++) begin
            check(spols[i] == exp_pol, "R11 polarity", int'(spols[i]), int'(exp_pol));
            exp_pol = !exp_pol;
            if (i > 0)
                check(starts[i] - starts[i-1] == 1024, "R11 spacing",
                      starts[i] - starts[i-1], 1024);
        end
        repeat (1200) @(negedge clk);
        run_period("R11 continuity after test");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule